// File: doc/BRIEF.md
# Branch Squash Controller with Delay-Slot Tracking

This block decides which in-flight instructions to discard when a branch that has reached the second execute stage (X1) turns out to be mispredicted. The pipeline is scalar with six stages: F, D, I, X0, X1 and W. Branch outcomes are known only at the end of X1. The four stages younger than X1 each report a valid bit and a sequence tag. When a mispredict is signalled, the controller returns one kill bit per younger stage, the number of real instructions squashed, and a fetch-redirect request. The pipeline clears the valid bit of every killed stage on the following clock edge.

With a delay slot, the instruction that directly follows the branch must always complete. Its tag is the branch tag plus one, modulo the tag width. The controller finds that instruction in whichever younger stage holds it and spares it. If a fetch stall means it has not arrived yet, the controller holds the redirect until exactly one more fetch has entered. A parameter removes the delay slot. In that case every valid younger instruction is squashed and the redirect is issued at once.

Top module: `squash_ctrl`

## Requirements
- R1: After reset `ds_pending_o` is low, and with `mispredict_i` and `fetch_i` low the outputs `kill_o`, `kill_cnt_o` and `redirect_o` are all zero.
- R2: While `mispredict_i` is low, `kill_o` and `kill_cnt_o` are zero.
- R3: With the delay slot enabled, a mispredict sets `kill_o[s]` for every valid younger stage s whose tag differs from the branch tag plus one, modulo 2^TAG_W. A stage holding that tag is spared. Bit 0 is F, 1 is D, 2 is I and 3 is X0.
- R4: A stage whose valid bit is low is never killed, and `kill_cnt_o` always equals the number of set bits in `kill_o`.
- R5: With the delay slot enabled, a mispredict raises `redirect_o` in the same cycle if the delay-slot instruction sits in a younger stage or `fetch_i` is high in that cycle. `ds_pending_o` then stays low.
- R6: With the delay slot enabled, a mispredict with the delay-slot instruction absent and `fetch_i` low leaves `redirect_o` low and sets `ds_pending_o` from the next cycle.
- R7: While `ds_pending_o` is high, a cycle with `fetch_i` high raises `redirect_o` and clears `ds_pending_o` on the next edge. A cycle with `fetch_i` low leaves `redirect_o` low and keeps the flag set.
- R8: While `ds_pending_o` is high, `mispredict_i` is ignored and no stage is killed.
- R9: With NO_DELAY_SLOT set, a mispredict kills every valid younger stage whatever its tag, raises `redirect_o` in the same cycle, and `ds_pending_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mispredict_i | input | 1 | Branch in X1 resolved as mispredicted |
| br_tag_i | input | TAG_W | Sequence tag of the branch in X1 |
| stg_valid_i | input | N_YOUNG | Valid bit per younger stage (0=F, 1=D, 2=I, 3=X0) |
| stg_tag_i | input | N_YOUNG*TAG_W | Packed tags, stage s in bits [s*TAG_W +: TAG_W] |
| fetch_i | input | 1 | An instruction enters F on the next edge |
| kill_o | output | N_YOUNG | Per-stage squash request |
| kill_cnt_o | output | $clog2(N_YOUNG+1) | Number of valid instructions squashed this cycle |
| redirect_o | output | 1 | Steer fetch to the corrected path |
| ds_pending_o | output | 1 | Delay-slot instruction still awaited |

## Verification
Two instances share the same stimulus, one with the delay slot and one without. The sweep covers all sixteen bubble patterns in the younger stages. For each pattern, the delay-slot instruction is placed in each of the four stages and also left absent. Each case is run with and without a fetch arriving in the mispredict cycle, and with branch tags that include the wrap from the maximum tag to zero. The delay-slot positions separate sparing from blind flushing. The bubble patterns separate valid-gated kills and counts from raw stage kills. The absent-slot cases, followed by a masked mispredict and then a late fetch, show whether the redirect is held back for exactly one fetch.

// File: rtl/squash_pkg.sv
package squash_pkg;
  typedef enum logic [1:0] {STG_F = 2'd0, STG_D = 2'd1, STG_I = 2'd2, STG_X0 = 2'd3} young_stage_e;
  localparam int unsigned N_YOUNG_STAGES = 4;
endpackage

// File: rtl/sq_ds_match.sv
module sq_ds_match #(
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned N_YOUNG = 4
) (
  input  logic [TAG_W-1:0]         br_tag_i,
  input  logic [N_YOUNG-1:0]       stg_valid_i,
  input  logic [N_YOUNG*TAG_W-1:0] stg_tag_i,
  output logic [N_YOUNG-1:0]       match_o,
  output logic                     found_o
);
  logic [TAG_W-1:0] ds_tag;
  assign ds_tag = br_tag_i + TAG_W'(1);

  for (genvar s = 0; s < N_YOUNG; s++) begin : g_stage
    assign match_o[s] = stg_valid_i[s] && (stg_tag_i[s*TAG_W +: TAG_W] == ds_tag);
  end

  assign found_o = |match_o;
endmodule

// File: rtl/sq_kill_gen.sv
module sq_kill_gen #(
  parameter int unsigned N_YOUNG = 4,
  parameter bit          DS_EN   = 1'b1
) (
  input  logic               flush_en_i,
  input  logic [N_YOUNG-1:0] stg_valid_i,
  input  logic [N_YOUNG-1:0] ds_match_i,
  output logic [N_YOUNG-1:0] kill_o
);
  if (DS_EN) begin : g_ds
    assign kill_o = flush_en_i ? (stg_valid_i & ~ds_match_i) : '0;
  end else begin : g_nds
    assign kill_o = flush_en_i ? stg_valid_i : '0;
  end
endmodule

// File: rtl/sq_popcnt.sv
module sq_popcnt #(
  parameter int unsigned N     = 4,
  localparam int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     bits_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CNT_W'(bits_i[i]);
  end
endmodule

// File: rtl/sq_pending.sv
module sq_pending #(
  parameter bit DS_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mispredict_i,
  input  logic ds_found_i,
  input  logic fetch_i,
  output logic flush_en_o,
  output logic redirect_o,
  output logic pending_o
);
  logic pend_q, pend_d;

  always_comb begin
    flush_en_o = mispredict_i && !pend_q;
    redirect_o = (flush_en_o && (!DS_EN || ds_found_i || fetch_i)) || (pend_q && fetch_i);
    // hold redirect until the missing delay slot has been fetched
    if (pend_q) pend_d = !fetch_i;
    else        pend_d = DS_EN && flush_en_o && !ds_found_i && !fetch_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/squash_ctrl.sv
module squash_ctrl #(
  parameter int unsigned TAG_W         = 4,
  parameter int unsigned N_YOUNG       = squash_pkg::N_YOUNG_STAGES,
  parameter bit          NO_DELAY_SLOT = 1'b0,
  localparam int unsigned CNT_W        = $clog2(N_YOUNG + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mispredict_i,
  input  logic [TAG_W-1:0]         br_tag_i,
  input  logic [N_YOUNG-1:0]       stg_valid_i,
  input  logic [N_YOUNG*TAG_W-1:0] stg_tag_i,
  input  logic                     fetch_i,
  output logic [N_YOUNG-1:0]       kill_o,
  output logic [CNT_W-1:0]         kill_cnt_o,
  output logic                     redirect_o,
  output logic                     ds_pending_o
);
  localparam bit DS_EN = !NO_DELAY_SLOT;

  logic [N_YOUNG-1:0] ds_match;
  logic               ds_found;
  logic               flush_en;

  sq_ds_match #(.TAG_W(TAG_W), .N_YOUNG(N_YOUNG)) u_match (
    .br_tag_i   (br_tag_i),
    .stg_valid_i(stg_valid_i),
    .stg_tag_i  (stg_tag_i),
    .match_o    (ds_match),
    .found_o    (ds_found)
  );

  sq_pending #(.DS_EN(DS_EN)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mispredict_i(mispredict_i),
    .ds_found_i  (ds_found),
    .fetch_i     (fetch_i),
    .flush_en_o  (flush_en),
    .redirect_o  (redirect_o),
    .pending_o   (ds_pending_o)
  );

  sq_kill_gen #(.N_YOUNG(N_YOUNG), .DS_EN(DS_EN)) u_kill (
    .flush_en_i (flush_en),
    .stg_valid_i(stg_valid_i),
    .ds_match_i (ds_match),
    .kill_o     (kill_o)
  );

  sq_popcnt #(.N(N_YOUNG)) u_cnt (
    .bits_i(kill_o),
    .cnt_o (kill_cnt_o)
  );
endmodule

// File: rtl/squash_ctrl_chk.sv
module squash_ctrl_chk #(
  parameter int unsigned TAG_W         = 4,
  parameter int unsigned N_YOUNG       = 4,
  parameter bit          NO_DELAY_SLOT = 1'b0,
  localparam int unsigned CNT_W        = $clog2(N_YOUNG + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     mispredict_i,
  input logic [N_YOUNG-1:0]       stg_valid_i,
  input logic                     fetch_i,
  input logic [N_YOUNG-1:0]       kill_o,
  input logic [CNT_W-1:0]         kill_cnt_o,
  input logic                     redirect_o,
  input logic                     ds_pending_o
);
  AST_NO_KILL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mispredict_i |-> kill_o == '0); // R2
  AST_KILL_VALID_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_o & ~stg_valid_i) == '0); // R4
  AST_CNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_cnt_o == CNT_W'($countones(kill_o))); // R4
  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_i && !ds_pending_o && !redirect_o |=> ds_pending_o); // R6
  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_pending_o && fetch_i |-> redirect_o ##1 !ds_pending_o); // R7
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_pending_o && !fetch_i |-> !redirect_o ##1 ds_pending_o); // R7
  AST_PEND_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_pending_o |-> kill_o == '0); // R8
  AST_NDS_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    NO_DELAY_SLOT |-> !ds_pending_o); // R9
endmodule

bind squash_ctrl squash_ctrl_chk #(
  .TAG_W(TAG_W), .N_YOUNG(N_YOUNG), .NO_DELAY_SLOT(NO_DELAY_SLOT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mispredict_i(mispredict_i),
  .stg_valid_i (stg_valid_i),
  .fetch_i     (fetch_i),
  .kill_o      (kill_o),
  .kill_cnt_o  (kill_cnt_o),
  .redirect_o  (redirect_o),
  .ds_pending_o(ds_pending_o)
);

// File: tb/squash_ctrl_tb_top.sv
module squash_ctrl_tb_top;
  localparam int unsigned TAG_W = 4;
  localparam int unsigned NY    = 4;
  localparam int unsigned CW    = $clog2(NY + 1);

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            mispredict = 1'b0;
  logic [TAG_W-1:0] br_tag = '0;
  logic [NY-1:0]   valid = '0;
  logic [NY*TAG_W-1:0] tags = '0;
  logic            fetch = 1'b0;

  logic [NY-1:0] kill_d, kill_n;
  logic [CW-1:0] cnt_d, cnt_n;
  logic          redir_d, redir_n, pend_d, pend_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  squash_ctrl #(.TAG_W(TAG_W), .N_YOUNG(NY), .NO_DELAY_SLOT(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mispredict_i(mispredict), .br_tag_i(br_tag),
    .stg_valid_i(valid), .stg_tag_i(tags), .fetch_i(fetch),
    .kill_o(kill_d), .kill_cnt_o(cnt_d), .redirect_o(redir_d), .ds_pending_o(pend_d));

  squash_ctrl #(.TAG_W(TAG_W), .N_YOUNG(NY), .NO_DELAY_SLOT(1'b1)) dut_nds_i (
    .clk_i(clk), .rst_ni(rst_ni), .mispredict_i(mispredict), .br_tag_i(br_tag),
    .stg_valid_i(valid), .stg_tag_i(tags), .fetch_i(fetch),
    .kill_o(kill_n), .kill_cnt_o(cnt_n), .redirect_o(redir_n), .ds_pending_o(pend_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int pop(input int v);
    int c = 0;
    for (int i = 0; i < NY; i++) c += (v >> i) & 1;
    return c;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int btags[3] = '{3, 15, 9};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(pend_d == 1'b0, "R1 pending", pend_d, 0);
    chk(kill_d == '0 && cnt_d == '0, "R1 kill", kill_d, 0);
    chk(redir_d == 1'b0 && redir_n == 1'b0, "R1 redirect", redir_d, 0);

    foreach (btags[bi]) begin
      for (int vp = 0; vp < 16; vp++) begin
        for (int dp = 0; dp <= NY; dp++) begin
          for (int fe = 0; fe < 2; fe++) begin
            int v, exp_kill;
            bit found, exp_pend;
            @(negedge clk);
            // R2 idle cycle with stage contents present
            v = vp | ((dp < NY) ? (1 << dp) : 0);
            br_tag = TAG_W'(btags[bi]);
            for (int s = 0; s < NY; s++)
              tags[s*TAG_W +: TAG_W] = (s == dp) ? TAG_W'(btags[bi] + 1) : TAG_W'(btags[bi] + 5 + s);
            valid = NY'(v);
            mispredict = 1'b0; fetch = 1'b0;
            #1;
            chk(kill_d == '0 && kill_n == '0 && cnt_d == '0, "R2 idle kill", kill_d, 0);
            @(negedge clk);
            mispredict = 1'b1; fetch = bit'(fe);
            #1;
            found = (dp < NY);
            exp_kill = v & ~(found ? (1 << dp) : 0);
            exp_pend = !found && (fe == 0);
            chk(kill_d == NY'(exp_kill), "R3 spare delay slot", kill_d, exp_kill);
            chk(cnt_d == CW'(pop(exp_kill)), "R4 kill count", cnt_d, pop(exp_kill));
            chk(redir_d == !exp_pend, "R5 redirect", redir_d, !exp_pend);
            chk(kill_n == NY'(v) && cnt_n == CW'(pop(v)), "R9 flush all", kill_n, v);
            chk(redir_n == 1'b1, "R9 redirect", redir_n, 1);
            @(negedge clk);
            mispredict = 1'b0; fetch = 1'b0;
            #1;
            chk(pend_d == exp_pend, "R6 pending", pend_d, exp_pend);
            chk(pend_n == 1'b0, "R9 no pending", pend_n, 0);
            if (exp_pend) begin
              chk(redir_d == 1'b0, "R7 hold redirect", redir_d, 0);
              @(negedge clk);
              valid = '1; mispredict = 1'b1;
              #1;
              chk(kill_d == '0 && cnt_d == '0, "R8 masked mispredict", kill_d, 0);
              chk(redir_d == 1'b0, "R8 no redirect", redir_d, 0);
              @(negedge clk);
              mispredict = 1'b0; fetch = 1'b1;
              #1;
              chk(pend_d == 1'b1, "R7 pending kept", pend_d, 1);
              chk(redir_d == 1'b1, "R7 late redirect", redir_d, 1);
              @(negedge clk);
              fetch = 1'b0;
              #1;
              chk(pend_d == 1'b0, "R7 pending cleared", pend_d, 0);
              chk(redir_d == 1'b0, "R7 single redirect", redir_d, 0);
            end
          end
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule